// File: doc/BRIEF.md
# DAC Sample Buffer with Occupancy Flags

This block is a per-channel sample store that sits between a host write path and a playback engine that converts samples to analog. The host pushes 16-bit two's-complement DAC codes one per write strobe; the playback engine pulls them one per read strobe, in the order they were written. The codes are passed through untouched. In bipolar use 0x7FFF is the top of the positive range and 0x8000 the bottom of the negative range. In unipolar use 0x0000 to 0xFFFF runs from zero to full scale.

An occupancy counter tracks how many samples are held. Four programmable levels turn that count into a status word: almost empty, low limit, high limit and almost full. Fixed empty and full conditions are added, together with a sample-done indication forwarded from the playback engine. Every status bit has a real-time copy. It also has a sticky copy that remembers the bit was ever set until the host clears it with a bitmask. A flush command discards all stored samples. A running count of accepted writes lets the host see how many samples were actually taken.

Top module: `smpbuf_top`

## Requirements
- R1: After reset the fill count, accepted-write count, read data and sticky status are all zero, and the live status word is 0x07 (empty, almost empty and low limit set). The reset thresholds are 0 for almost empty and low limit, and DEPTH for high limit and almost full.
- R2: Samples leave in the order they were written. rdData takes the oldest sample on the clock edge that follows a read strobe that is not ignored, and holds its value at all other times.
- R3: A write while the count equals DEPTH is dropped and does not advance acceptCount. A read while the count is zero changes nothing. The count never exceeds DEPTH.
- R4: A read and a write that are both taken in the same cycle leave the count unchanged.
- R5: flushReq empties the buffer and sets the count to 0. It takes precedence over a write or a read in the same cycle, and that write is not counted.
- R6: Status bit 0 (empty) is set when the count is zero. Status bit 5 (full) is set when the count equals DEPTH.
- R7: Status bit 1 (almost empty) is set when count <= the almost-empty level. Status bit 2 (low limit) is set when count <= the low level.
- R8: Status bit 3 (high limit) is set when count >= the high level. Status bit 4 (almost full) is set when count >= the almost-full level.
- R9: A level is written with thrWe, thrSel and thrData. thrSel selects 0 = almost empty, 1 = low, 2 = high, 3 = almost full. The live status reflects a count or level register one clock edge after that register changes.
- R10: The sticky status ORs in the live status one edge later. A sticky bit is cleared only when latchClrEn is high and the matching latchClrMask bit is 1. A set in the same cycle wins over a clear.
- R11: Status bit 6 follows sampleDoneIn one edge later. Bit 7 is always 0 in both the live and the sticky word.
- R12: acceptCount increments by one for each write that is taken, and wraps at its width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Host write strobe |
| wrData | input | 16 | Sample code to store |
| rdEn | input | 1 | Playback read strobe |
| rdData | output | 16 | Most recently read sample |
| flushReq | input | 1 | Discard all stored samples |
| thrWe | input | 1 | Level register write strobe |
| thrSel | input | 2 | Level register select |
| thrData | input | CNT_W | Level value |
| latchClrEn | input | 1 | Sticky status clear strobe |
| latchClrMask | input | 8 | Sticky bits to clear |
| sampleDoneIn | input | 1 | Done indication from playback |
| fillCount | output | CNT_W | Samples currently held |
| statusLive | output | 8 | Real-time status word |
| statusLatched | output | 8 | Sticky status word |
| acceptCount | output | ACC_W | Accepted writes, wrapping |

## Verification
A fault in the pointers or the storage shows up as a wrong rdData value on the edge after the read that hits the damaged entry. A count that drifts by a single sample is visible on fillCount at once, and in the flag bits one edge later. Because every output is compared with a queue model on every clock, a divergence is reported within a cycle of the moment it becomes observable. Sticky-bit faults show at the first clear or set that the bench applies, since the sticky word is compared continuously as well.

// File: rtl/smpbuf_pkg.sv
package smpbuf_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic push;
    logic pop;
    logic flush;
  } bufStrobe_t;

  // status word bit positions
  localparam int ST_EMPTY  = 0;
  localparam int ST_AEMPTY = 1;
  localparam int ST_LOW    = 2;
  localparam int ST_HIGH   = 3;
  localparam int ST_AFULL  = 4;
  localparam int ST_FULL   = 5;
  localparam int ST_DONE   = 6;
  localparam int ST_W      = 8;

  typedef enum logic [1:0] {
    LVL_AEMPTY = 2'd0,
    LVL_LOW    = 2'd1,
    LVL_HIGH   = 2'd2,
    LVL_AFULL  = 2'd3
  } lvlSel_t;
endpackage

// File: rtl/smpbuf_dpath.sv
module smpbuf_dpath
  import smpbuf_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  bufStrobe_t        strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] store [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (strobe.push) store[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobe.push) wrPtr <= bump(wrPtr);
      if (strobe.pop)  rdPtr <= bump(rdPtr);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)           rdData <= '0;
    else if (strobe.pop) rdData <= store[rdPtr];
  end
endmodule

// File: rtl/smpbuf_ctrl.sv
module smpbuf_ctrl
  import smpbuf_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int ACC_W = 16,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic             flushReq,
  input  logic             thrWe,
  input  logic [1:0]       thrSel,
  input  logic [CNT_W-1:0] thrData,
  input  logic             latchClrEn,
  input  logic [ST_W-1:0]  latchClrMask,
  input  logic             sampleDoneIn,
  output bufStrobe_t       strobe,
  output logic [CNT_W-1:0] fillCount,
  output logic [ST_W-1:0]  statusLive,
  output logic [ST_W-1:0]  statusLatched,
  output logic [ACC_W-1:0] acceptCount
);
  localparam logic [CNT_W-1:0] MAXC = CNT_W'(DEPTH);
  localparam logic [ST_W-1:0]  LIVE_RST = ST_W'(7);

  logic [CNT_W-1:0] lvlAEmpty, lvlLow, lvlHigh, lvlAFull;
  logic [ST_W-1:0]  liveNext;

  always_comb begin
    strobe.flush = flushReq;
    strobe.push  = wrEn && !flushReq && (fillCount != MAXC);
    strobe.pop   = rdEn && !flushReq && (fillCount != '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.flush)           fillCount <= '0;
    else if (strobe.push && !strobe.pop) fillCount <= fillCount + 1'b1;
    else if (strobe.pop && !strobe.push) fillCount <= fillCount - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)            acceptCount <= '0;
    else if (strobe.push) acceptCount <= acceptCount + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lvlAEmpty <= '0;
      lvlLow    <= '0;
      lvlHigh   <= MAXC;
      lvlAFull  <= MAXC;
    end else if (thrWe) begin
      unique case (lvlSel_t'(thrSel))
        LVL_AEMPTY: lvlAEmpty <= thrData;
        LVL_LOW:    lvlLow    <= thrData;
        LVL_HIGH:   lvlHigh   <= thrData;
        LVL_AFULL:  lvlAFull  <= thrData;
      endcase
    end
  end

  always_comb begin
    liveNext            = '0;
    liveNext[ST_EMPTY]  = (fillCount == '0);
    liveNext[ST_AEMPTY] = (fillCount <= lvlAEmpty);
    liveNext[ST_LOW]    = (fillCount <= lvlLow);
    liveNext[ST_HIGH]   = (fillCount >= lvlHigh);
    liveNext[ST_AFULL]  = (fillCount >= lvlAFull);
    liveNext[ST_FULL]   = (fillCount == MAXC);
    liveNext[ST_DONE]   = sampleDoneIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) statusLive <= LIVE_RST;
    else       statusLive <= liveNext;
  end

  for (genvar b = 0; b < ST_W; b++) begin : g_sticky
    always_ff @(posedge clk) begin
      if (!rstN) statusLatched[b] <= 1'b0;
      else statusLatched[b] <= (statusLatched[b] & ~(latchClrEn & latchClrMask[b]))
                               | statusLive[b];
    end
  end
endmodule

// File: rtl/smpbuf_top.sv
module smpbuf_top
  import smpbuf_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  parameter int ACC_W  = 16,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  input  logic              flushReq,
  input  logic              thrWe,
  input  logic [1:0]        thrSel,
  input  logic [CNT_W-1:0]  thrData,
  input  logic              latchClrEn,
  input  logic [7:0]        latchClrMask,
  input  logic              sampleDoneIn,
  output logic [CNT_W-1:0]  fillCount,
  output logic [7:0]        statusLive,
  output logic [7:0]        statusLatched,
  output logic [ACC_W-1:0]  acceptCount
);
  bufStrobe_t strobe;

  smpbuf_ctrl #(.DEPTH(DEPTH), .ACC_W(ACC_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .flushReq(flushReq),
    .thrWe(thrWe), .thrSel(thrSel), .thrData(thrData),
    .latchClrEn(latchClrEn), .latchClrMask(latchClrMask),
    .sampleDoneIn(sampleDoneIn), .strobe(strobe), .fillCount(fillCount),
    .statusLive(statusLive), .statusLatched(statusLatched),
    .acceptCount(acceptCount)
  );

  smpbuf_dpath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData), .rdData(rdData)
  );
endmodule

// File: rtl/smpbuf_chk.sv
module smpbuf_chk #(
  parameter int DEPTH = 16,
  parameter int ACC_W = 16,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic             rdEn,
  input logic             flushReq,
  input logic             latchClrEn,
  input logic [CNT_W-1:0] fillCount,
  input logic [7:0]       statusLive,
  input logic [7:0]       statusLatched,
  input logic [ACC_W-1:0] acceptCount
);
  localparam logic [CNT_W-1:0] MAXC = CNT_W'(DEPTH);

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    fillCount <= MAXC);

  assert_full_drop_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !rdEn && !flushReq && fillCount == MAXC)
      |=> (fillCount == MAXC) && $stable(acceptCount));

  assert_pair_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && rdEn && !flushReq && fillCount != '0 && fillCount != MAXC)
      |=> $stable(fillCount));

  assert_flush_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    flushReq |=> (fillCount == '0));

  assert_empty_flag_R6: assert property (@(posedge clk) disable iff (!rstN)
    statusLive[0] == ($past(fillCount) == '0));

  assert_full_flag_R6: assert property (@(posedge clk) disable iff (!rstN)
    statusLive[5] == ($past(fillCount) == MAXC));

  assert_sticky_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !latchClrEn |=> ((statusLatched & $past(statusLatched)) == $past(statusLatched)));

  assert_reserved_zero_R11: assert property (@(posedge clk) disable iff (!rstN)
    !statusLive[7] && !statusLatched[7]);
endmodule

bind smpbuf_top smpbuf_chk #(.DEPTH(DEPTH), .ACC_W(ACC_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .flushReq(flushReq),
  .latchClrEn(latchClrEn), .fillCount(fillCount), .statusLive(statusLive),
  .statusLatched(statusLatched), .acceptCount(acceptCount)
);

// File: tb/test_smpbuf_top.sv
module test_smpbuf_top;
  localparam int DEPTH = 16;
  localparam int ACC_W = 16;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0, flushReq = 1'b0, thrWe = 1'b0;
  logic latchClrEn = 1'b0, sampleDoneIn = 1'b0;
  logic [15:0] wrData = '0;
  logic [1:0] thrSel = '0;
  logic [CNT_W-1:0] thrData = '0;
  logic [7:0] latchClrMask = '0;
  logic [15:0] rdData;
  logic [CNT_W-1:0] fillCount;
  logic [7:0] statusLive, statusLatched;
  logic [ACC_W-1:0] acceptCount;

  always #5 clk = ~clk;

  smpbuf_top #(.DEPTH(DEPTH), .ACC_W(ACC_W)) i_smpbuf_top (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn),
    .rdData(rdData), .flushReq(flushReq), .thrWe(thrWe), .thrSel(thrSel),
    .thrData(thrData), .latchClrEn(latchClrEn), .latchClrMask(latchClrMask),
    .sampleDoneIn(sampleDoneIn), .fillCount(fillCount), .statusLive(statusLive),
    .statusLatched(statusLatched), .acceptCount(acceptCount)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // behavioural reference
  logic [15:0] q[$];
  int mAe, mLo, mHi, mAf, mAcc;
  logic [15:0] mRd;
  logic [7:0] mLive, mLat;

  function automatic logic [7:0] flagsOf(int n, bit done);
    logic [7:0] f = '0;
    f[0] = (n == 0);
    f[1] = (n <= mAe);
    f[2] = (n <= mLo);
    f[3] = (n >= mHi);
    f[4] = (n >= mAf);
    f[5] = (n == DEPTH);
    f[6] = done;
    return f;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      q.delete(); mAe = 0; mLo = 0; mHi = DEPTH; mAf = DEPTH;
      mAcc = 0; mRd = '0; mLive = 8'h07; mLat = '0;
    end else begin
      logic [7:0] nLive;
      int n;
      n = q.size();
      nLive = flagsOf(n, sampleDoneIn);
      mLat = (mLat & ~(latchClrEn ? latchClrMask : 8'h00)) | mLive;
      mLive = nLive;
      if (thrWe) begin
        case (thrSel)
          2'd0: mAe = int'(thrData);
          2'd1: mLo = int'(thrData);
          2'd2: mHi = int'(thrData);
          default: mAf = int'(thrData);
        endcase
      end
      if (flushReq) q.delete();
      else begin
        bit doPush, doPop;
        doPush = wrEn && (n < DEPTH);
        doPop  = rdEn && (n > 0);
        if (doPop) mRd = q.pop_front();
        if (doPush) begin q.push_back(wrData); mAcc = (mAcc + 1) % (1 << ACC_W); end
      end
    end
  end

  task automatic checkVal(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // compare against the model on every clock, away from the active edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      checkVal("R3 R4 R5 fillCount", fillCount, q.size());
      checkVal("R2 rdData", rdData, mRd);
      checkVal("R7 R8 R9 statusLive", statusLive, mLive);
      checkVal("R10 statusLatched", statusLatched, mLat);
      checkVal("R12 acceptCount", acceptCount, mAcc);
    end
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic setLvl(logic [1:0] s, int v);
    thrWe = 1'b1; thrSel = s; thrData = CNT_W'(v); tick(); thrWe = 1'b0;
  endtask

  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    checkVal("R1 fillCount", fillCount, 0);
    checkVal("R1 statusLive", statusLive, 8'h07);
    checkVal("R1 statusLatched", statusLatched, 8'h07);
    checkVal("R1 acceptCount", acceptCount, 0);
    checkVal("R1 rdData", rdData, 0);

    setLvl(2'd0, 2); setLvl(2'd1, 4); setLvl(2'd2, 10); setLvl(2'd3, 13);

    // fill beyond capacity
    for (int i = 0; i < DEPTH + 2; i++) begin
      wrEn = 1'b1; wrData = 16'h7FF8 + 16'(i); tick();
    end
    wrEn = 1'b0; tick();
    checkVal("R3 full drop count", fillCount, DEPTH);
    checkVal("R12 accepted", acceptCount, DEPTH);
    checkVal("R6 full bit5", statusLive[5], 1);
    checkVal("R8 high bit3 almost full bit4", statusLive[4:3], 2'b11);
    checkVal("R7 low bits clear", statusLive[2:0], 3'b000);

    // read and write together while full: write dropped
    wrEn = 1'b1; rdEn = 1'b1; wrData = 16'h1234; tick();
    wrEn = 1'b0; rdEn = 1'b0;
    checkVal("R3 full pair count", fillCount, DEPTH - 1);
    checkVal("R2 first out", rdData, 16'h7FF8);

    // drain with ordering, then extra reads on empty
    for (int i = 1; i < DEPTH + 3; i++) begin
      rdEn = 1'b1; tick();
      if (i < DEPTH) checkVal("R2 order", rdData, 16'h7FF8 + 16'(i));
    end
    rdEn = 1'b0; tick();
    checkVal("R3 empty read", fillCount, 0);
    checkVal("R3 empty read hold", rdData, 16'h7FF8 + 16'(DEPTH - 1));
    checkVal("R6 empty bit0", statusLive[0], 1);

    // simultaneous read and write mid-level
    for (int i = 0; i < 5; i++) begin wrEn = 1'b1; wrData = 16'h8000 + 16'(i); tick(); end
    rdEn = 1'b1; wrData = 16'hFFFF; tick(); tick();
    wrEn = 1'b0; rdEn = 1'b0;
    checkVal("R4 pair count", fillCount, 5);
    tick();
    checkVal("R7 low limit at 5 vs 4", statusLive[2], 0);
    setLvl(2'd1, 5); tick();
    checkVal("R9 low level moved", statusLive[2], 1);

    // sticky clear, done pulse
    latchClrEn = 1'b1; latchClrMask = 8'hFF; tick(); latchClrEn = 1'b0; tick();
    checkVal("R10 cleared except live", statusLatched, statusLive);
    sampleDoneIn = 1'b1; tick(); sampleDoneIn = 1'b0;
    checkVal("R11 done bit6", statusLive[6], 1);
    tick();
    checkVal("R11 done gone", statusLive[6], 0);
    checkVal("R10 done sticky", statusLatched[6], 1);

    // flush beats a same-cycle write
    flushReq = 1'b1; wrEn = 1'b1; rdEn = 1'b1; wrData = 16'h5555; tick();
    flushReq = 1'b0; wrEn = 1'b0; rdEn = 1'b0;
    checkVal("R5 flush count", fillCount, 0);
    checkVal("R5 flush no accept", acceptCount, DEPTH + 7);

    // mixed traffic
    for (int c = 0; c < 4000; c++) begin
      wrEn = ($urandom % 3) != 0;
      rdEn = ($urandom % 2) != 0;
      wrData = 16'($urandom);
      flushReq = ($urandom % 97) == 0;
      thrWe = ($urandom % 41) == 0;
      thrSel = 2'($urandom);
      thrData = CNT_W'($urandom % (DEPTH + 1));
      latchClrEn = ($urandom % 13) == 0;
      latchClrMask = 8'($urandom);
      sampleDoneIn = ($urandom % 29) == 0;
      tick();
    end
    {wrEn, rdEn, flushReq, thrWe, latchClrEn, sampleDoneIn} = '0;
    tick();

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule